// File: doc/BRIEF.md
# Coprocessor Register Debug Scan Chain

This block is a JTAG data-register chain that lets an external debugger reach the system-control coprocessor registers and start cache and TLB maintenance. The TAP controller supplies the chain-select, capture, shift and update strobes in the TCK domain along with TDI. The block returns TDO. Each packet is 37 bits long. Data bit 0 sits next to TDO, followed by a 4-bit operation code and then a read/write flag at the TDI end.

Work is done only in the update state. On a write update the data word goes to the selected register, or the selected maintenance strobe fires. A read update records which register to return. The value itself comes out in the next capture and the shift that follows it. A small register bank holds the eight accessible registers so the block can be exercised on its own.

Top module: `cp_debug_scan`

## Requirements
- R1: The chain is 37 bits. Bits [31:0] hold data, bits [35:32] hold the operation code and bit 36 holds the read/write flag. Shifting moves the chain toward TDO, TDI enters bit 36, and data bit 0 is both the first bit in and the first bit out.
- R2: On a rising TCK with capture and select both high, the read/write flag and the operation code load zero. The data field loads the register named by the pending read, or zero when no read is pending.
- R3: On an update with flag 1 (write) and a code from 1 to 7, the selected register takes the 32-bit data word at that edge. During that update cycle, the coprocessor port shows write enable high, the select equal to the code and the data word.
- R4: Code 0 reads a fixed identification value (parameter `ID_VALUE`). A write with code 0 changes nothing and raises no strobe.
- R5: A read takes two passes. An update with flag 0 and a code from 0 to 7 arms the read. The next capture returns that register in the data field.
- R6: A write update with code 8 pulses the cache-invalidate strobe and code 9 pulses the TLB-invalidate strobe, each for the single update cycle. At most one coprocessor action is active in any cycle.
- R7: A write update with code 10 pulses the single-entry invalidate strobe for one cycle and presents the data word on the entry address output.
- R8: A read update with code 8 to 15, and a write update with code 11 to 15, raise no strobe and change no register. Any update that is not a valid read leaves no read pending, so the next capture returns zero.
- R9: Shifting or capturing without an update changes no coprocessor state. While select is low, the capture, shift and update strobes are ignored.
- R10: TDO changes only on falling TCK and then shows chain bit 0.
- R11: After reset, registers 1 to 7 are zero, no read is pending, TDO is 0 and every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | Chain selected by the instruction register |
| capture_dr | input | 1 | Capture state strobe |
| shift_dr | input | 1 | Shift state strobe |
| update_dr | input | 1 | Update state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| cp_we | output | 1 | Register write enable (update cycle) |
| cp_sel | output | 3 | Register select for the write |
| cp_wdata | output | 32 | Register write data |
| inv_cache | output | 1 | Whole-cache invalidate strobe |
| inv_tlb | output | 1 | Whole-TLB invalidate strobe |
| inv_entry | output | 1 | Single TLB entry invalidate strobe |
| inv_addr | output | 32 | Address for the single-entry invalidate |

## Verification
Several properties are checked on every cycle by assertions. The capture always clears the flag and code fields. TDI lands at the top of the chain on each shift. The chain holds still when it is not being captured or shifted. Coprocessor actions occur only while an update of the selected chain is in progress, and never more than one at a time. Read-type updates never write. Register contents hold whenever no write is asserted. The bench scenarios cover the behaviour those checks cannot see: values written and read back for every code, the two-pass read pipelining, the pending read cleared by invalid updates, the ignored codes, the deselected chain, and the timing of TDO against the falling edge.

// File: rtl/cp_scan_pkg.sv
package cp_scan_pkg;

    localparam int DW      = 32;
    localparam int OPW     = 4;
    localparam int NREG    = 8;
    localparam int SELW    = $clog2(NREG);
    localparam int CHAIN_W = DW + OPW + 1;

    localparam logic [OPW-1:0] OP_ID        = 4'd0;
    localparam logic [OPW-1:0] OP_INV_CACHE = 4'd8;
    localparam logic [OPW-1:0] OP_INV_TLB   = 4'd9;
    localparam logic [OPW-1:0] OP_INV_ENTRY = 4'd10;

    typedef struct packed {
        logic           rw;
        logic [OPW-1:0] op;
        logic [DW-1:0]  data;
    } scan_pkt_t;

    typedef struct packed {
        logic            we;
        logic [SELW-1:0] sel;
        logic [DW-1:0]   wdata;
    } reg_req_t;

    typedef struct packed {
        logic          cache;
        logic          tlb;
        logic          entry;
        logic [DW-1:0] addr;
    } maint_t;

    function automatic logic is_reg_code(input logic [OPW-1:0] op);
        return op < OPW'(NREG);
    endfunction

endpackage

// File: rtl/cp_scan_shift.sv
module cp_scan_shift
    import cp_scan_pkg::*;
(
    input  logic          tck,
    input  logic          rst,
    input  logic          sel,
    input  logic          capture,
    input  logic          shift,
    input  logic          tdi,
    input  logic [DW-1:0] cap_data,
    output scan_pkt_t     pkt,
    output logic          tdo
);
    logic [CHAIN_W-1:0] sr;
    scan_pkt_t          cap_pkt;

    always_comb begin
        cap_pkt      = '0;
        cap_pkt.data = cap_data;
    end

    always_ff @(posedge tck) begin
        if (rst)
            sr <= '0;
        else if (sel && capture)
            sr <= cap_pkt;
        else if (sel && shift)
            sr <= {tdi, sr[CHAIN_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst)
            tdo <= 1'b0;
        else
            tdo <= sr[0];
    end

    assign pkt = scan_pkt_t'(sr);

    AST_CAPTURE_ZERO_HDR: assert property (@(posedge tck) disable iff (rst)
        sel && capture |=> sr[CHAIN_W-1 -: OPW+1] == '0); // R2
    AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (rst)
        sel && !capture && shift |=> sr[CHAIN_W-1] == $past(tdi)); // R1
    AST_CHAIN_HOLD: assert property (@(posedge tck) disable iff (rst)
        !(sel && (capture || shift)) |=> $stable(sr)); // R9
endmodule

// File: rtl/cp_scan_decode.sv
module cp_scan_decode
    import cp_scan_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            upd,
    input  scan_pkt_t       pkt,
    output reg_req_t        req,
    output maint_t          mnt,
    output logic            rd_valid,
    output logic [SELW-1:0] rd_sel
);
    always_comb begin
        req = '0;
        mnt = '0;
        if (upd && pkt.rw) begin
            if (is_reg_code(pkt.op)) begin
                if (pkt.op != OP_ID) begin
                    req.we    = 1'b1;
                    req.sel   = pkt.op[SELW-1:0];
                    req.wdata = pkt.data;
                end
            end else begin
                case (pkt.op)
                    OP_INV_CACHE: mnt.cache = 1'b1;
                    OP_INV_TLB:   mnt.tlb   = 1'b1;
                    OP_INV_ENTRY: begin
                        mnt.entry = 1'b1;
                        mnt.addr  = pkt.data;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_sel   <= '0;
        end else if (upd) begin
            rd_valid <= !pkt.rw && is_reg_code(pkt.op);
            rd_sel   <= pkt.op[SELW-1:0];
        end
    end

    AST_ONE_ACTION: assert property (@(posedge tck) disable iff (rst)
        $onehot0({req.we, mnt.cache, mnt.tlb, mnt.entry})); // R6
    AST_READ_NO_SIDE: assert property (@(posedge tck) disable iff (rst)
        upd && !pkt.rw |-> !req.we && !mnt.cache && !mnt.tlb && !mnt.entry); // R8
endmodule

// File: rtl/cp_reg_bank.sv
module cp_reg_bank
    import cp_scan_pkg::*;
#(
    parameter logic [DW-1:0] ID_VALUE = 32'h4107_7201
) (
    input  logic            tck,
    input  logic            rst,
    input  reg_req_t        req,
    input  logic [SELW-1:0] rd_sel,
    output logic [DW-1:0]   rdata
);
    logic [NREG-1:0][DW-1:0] regs;

    assign regs[0] = ID_VALUE;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge tck) begin
            if (rst)
                regs[g] <= '0;
            else if (req.we && req.sel == SELW'(g))
                regs[g] <= req.wdata;
        end
    end

    assign rdata = regs[rd_sel];

    AST_NO_ID_WRITE: assert property (@(posedge tck) disable iff (rst)
        req.we |-> req.sel != '0); // R4
    AST_BANK_STABLE: assert property (@(posedge tck) disable iff (rst)
        !req.we |=> $stable(regs)); // R9
endmodule

// File: rtl/cp_debug_scan.sv
module cp_debug_scan
    import cp_scan_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h4107_7201
) (
    input  logic        tck,
    input  logic        rst,
    input  logic        chain_sel,
    input  logic        capture_dr,
    input  logic        shift_dr,
    input  logic        update_dr,
    input  logic        tdi,
    output logic        tdo,
    output logic        cp_we,
    output logic [2:0]  cp_sel,
    output logic [31:0] cp_wdata,
    output logic        inv_cache,
    output logic        inv_tlb,
    output logic        inv_entry,
    output logic [31:0] inv_addr
);
    scan_pkt_t       pkt;
    reg_req_t        req;
    maint_t          mnt;
    logic            rd_valid;
    logic [SELW-1:0] rd_sel;
    logic [DW-1:0]   rdata;
    logic [DW-1:0]   cap_data;
    logic            upd;

    assign upd      = update_dr && chain_sel;
    assign cap_data = rd_valid ? rdata : '0;

    cp_scan_shift u_shift (
        .tck(tck), .rst(rst), .sel(chain_sel), .capture(capture_dr),
        .shift(shift_dr), .tdi(tdi), .cap_data(cap_data), .pkt(pkt), .tdo(tdo)
    );

    cp_scan_decode u_dec (
        .tck(tck), .rst(rst), .upd(upd), .pkt(pkt), .req(req), .mnt(mnt),
        .rd_valid(rd_valid), .rd_sel(rd_sel)
    );

    cp_reg_bank #(.ID_VALUE(ID_VALUE)) u_bank (
        .tck(tck), .rst(rst), .req(req), .rd_sel(rd_sel), .rdata(rdata)
    );

    assign cp_we     = req.we;
    assign cp_sel    = req.sel;
    assign cp_wdata  = req.wdata;
    assign inv_cache = mnt.cache;
    assign inv_tlb   = mnt.tlb;
    assign inv_entry = mnt.entry;
    assign inv_addr  = mnt.addr;

    AST_ACT_AT_UPDATE: assert property (@(posedge tck) disable iff (rst)
        (cp_we || inv_cache || inv_tlb || inv_entry) |-> update_dr && chain_sel); // R9
endmodule

// File: tb/tb_cp_debug_scan.sv
module tb_cp_debug_scan;
    localparam logic [31:0] ID = 32'h4107_7201;

    logic tck = 0, rst = 1, chain_sel = 1, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo, cp_we, inv_cache, inv_tlb, inv_entry;
    logic [2:0]  cp_sel;
    logic [31:0] cp_wdata, inv_addr;

    int checks = 0, fails = 0;
    logic [31:0] exp_r [8];
    logic [36:0] dout;
    logic        s_we, s_c, s_t, s_e;
    logic [2:0]  s_sel;
    logic [31:0] s_wd, s_addr;
    logic        tdo_glitch;

    always #10 tck = ~tck;

    cp_debug_scan #(.ID_VALUE(ID)) dut (.*);

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic scan(input logic rw, input logic [3:0] op, input logic [31:0] d, input bit do_upd);
        logic [36:0] din;
        din = {rw, op, d};
        tdo_glitch = 0;
        @(negedge tck); #1 capture_dr = 1;
        @(negedge tck); #1 capture_dr = 0;
        for (int i = 0; i < 37; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            shift_dr = 1;
            @(posedge tck); #1;
            if (tdo !== dout[i]) tdo_glitch = 1;
            @(negedge tck); #1;
        end
        shift_dr = 0;
        update_dr = do_upd;
        #2;
        s_we = cp_we; s_sel = cp_sel; s_wd = cp_wdata;
        s_c = inv_cache; s_t = inv_tlb; s_e = inv_entry; s_addr = inv_addr;
        @(negedge tck); #1 update_dr = 0;
        chk(!tdo_glitch, "R10 tdo changed on rising edge", 64'(tdo_glitch), 64'd0);
    endtask

    task automatic read_chk(input logic [3:0] c, input string rq);
        scan(1'b0, c, 32'hFFFF_FFFF, 1);
        scan(1'b0, c, 32'h0, 1);
        chk(dout == {5'b0, exp_r[c[2:0]]}, rq, 64'(dout), 64'({5'b0, exp_r[c[2:0]]}));
    endtask

    function automatic logic [31:0] pat(input int c, input int k);
        return 32'h1357_9BDF ^ (32'(c) * 32'h0101_0101) ^ (32'(k) << 28);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge tck);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        exp_r[0] = ID;
        for (int i = 1; i < 8; i++) exp_r[i] = '0;
        repeat (3) @(negedge tck);
        #1 rst = 0;
        #2;
        chk(tdo == 0 && !cp_we && !inv_cache && !inv_tlb && !inv_entry, "R11 reset outputs",
            64'({tdo, cp_we, inv_cache, inv_tlb, inv_entry}), 64'd0);

        // R11 / R2: first capture with nothing pending returns zero
        scan(1'b0, 4'd3, 32'h0, 1);
        chk(dout == '0, "R11 no pending read", 64'(dout), 64'd0);
        for (int c = 1; c < 8; c++) read_chk(4'(c), "R11 reset register value");

        // R3: write sweep
        for (int k = 0; k < 2; k++)
            for (int c = 1; c < 8; c++) begin
                scan(1'b1, 4'(c), pat(c, k), 1);
                exp_r[c] = pat(c, k);
                chk(s_we && s_sel == 3'(c) && s_wd == pat(c, k) && !s_c && !s_t && !s_e,
                    "R3 write port", 64'({s_we, s_sel, s_wd}), 64'({1'b1, 3'(c), pat(c, k)}));
            end
        // R5 / R1 / R2: read back every register
        for (int c = 0; c < 8; c++) read_chk(4'(c), "R5 read back");

        // R4: write to identification ignored
        scan(1'b1, 4'd0, 32'hDEAD_BEEF, 1);
        chk(!s_we && !s_c && !s_t && !s_e, "R4 id write no strobe", 64'({s_we, s_c, s_t, s_e}), 64'd0);
        read_chk(4'd0, "R4 id value");

        // R6 / R7: maintenance commands
        scan(1'b1, 4'd8, 32'h1111_0000, 1);
        chk(s_c && !s_t && !s_e && !s_we, "R6 cache invalidate", 64'({s_c, s_t, s_e, s_we}), 64'h8);
        @(negedge tck); #1;
        chk(!inv_cache, "R6 strobe one cycle", 64'(inv_cache), 64'd0);
        scan(1'b1, 4'd9, 32'h2222_0000, 1);
        chk(!s_c && s_t && !s_e && !s_we, "R6 tlb invalidate", 64'({s_c, s_t, s_e, s_we}), 64'h4);
        scan(1'b1, 4'd10, 32'hC0DE_1000, 1);
        chk(s_e && s_addr == 32'hC0DE_1000 && !s_c && !s_t, "R7 entry invalidate",
            64'({s_e, s_addr}), 64'({1'b1, 32'hC0DE_1000}));

        // R5 pipelining, R8 read-type command clears pending
        scan(1'b0, 4'd3, 32'h0, 1);
        scan(1'b0, 4'd9, 32'h0, 1);
        chk(dout == {5'b0, exp_r[3]}, "R5 read result next capture", 64'(dout), 64'(exp_r[3]));
        chk(!s_we && !s_c && !s_t && !s_e, "R8 read with command code", 64'({s_we, s_c, s_t, s_e}), 64'd0);
        scan(1'b0, 4'd1, 32'h0, 1);
        chk(dout == '0, "R8 pending cleared", 64'(dout), 64'd0);

        // R8: invalid codes 11..15, both flag values
        for (int c = 11; c < 16; c++) begin
            scan(1'b1, 4'(c), 32'hABCD_0000, 1);
            chk(!s_we && !s_c && !s_t && !s_e, "R8 invalid write code", 64'({s_we, s_c, s_t, s_e}), 64'd0);
            scan(1'b0, 4'(c), 32'h0, 1);
            chk(!s_we && !s_c && !s_t && !s_e, "R8 invalid read code", 64'({s_we, s_c, s_t, s_e}), 64'd0);
        end
        scan(1'b0, 4'd2, 32'h0, 1);
        chk(dout == '0, "R8 invalid code leaves no read", 64'(dout), 64'd0);
        for (int c = 1; c < 8; c++) read_chk(4'(c), "R8 registers unchanged");

        // R9: shift without update
        scan(1'b1, 4'd2, 32'h5555_AAAA, 0);
        chk(!s_we, "R9 no update no write", 64'(s_we), 64'd0);
        read_chk(4'd2, "R9 shift only keeps state");

        // R9: deselected chain ignores everything
        chain_sel = 0;
        scan(1'b1, 4'd4, 32'h7777_7777, 1);
        chk(!s_we && !s_c && !s_t && !s_e, "R9 deselected update", 64'({s_we, s_c, s_t, s_e}), 64'd0);
        scan(1'b1, 4'd8, 32'h0, 1);
        chk(!s_c, "R9 deselected command", 64'(s_c), 64'd0);
        chain_sel = 1;
        read_chk(4'd4, "R9 deselected keeps state");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule